// File: doc/BRIEF.md
# Multiprocessor-Aware Asynchronous Serial Transmitter

This block turns characters into asynchronous serial frames. Software-side logic writes a character, and a multiprocessor flag with it, into a single holding register. A transmit-data-register-empty flag (TDRE) tells the writer when that register can take the next character. When the holding register has data and the transmitter is enabled, the character moves into a shift register on a bit-rate tick. The frame then goes out one bit per tick interval.

The frame shape is set by five control inputs:
- 7 or 8 data bits.
- An optional even or odd parity bit, computed over the data bits only.
- One or two stop bits.
- In multiprocessor mode, an extra address/data marker bit placed after the last data bit.

The format inputs are sampled at the moment a character is transferred into the shift register. Dropping the enable cuts the frame on the wire. The holding register and TDRE are not touched by that, so a pending character goes out once the enable returns.

Top module: `mptx_top`

## Requirements
- R1: After reset the serial line `txd` is high and `tdre` is 1.
- R2: A write (`wr_en` high on a clock edge) sets `tdre` to 0 from the next cycle. The transfer of the held character into the shift register sets `tdre` back to 1 in the cycle after that transfer edge, unless a write occurs on the same edge.
- R3: A transfer happens only on a clock edge where `bit_tick` is high, `tx_en` is high, data is pending, and no frame is running or the running frame is on its last bit. From the next cycle `txd` drives a start bit of 0. Each subsequent bit begins on the next `bit_tick` edge, and data is sent least significant bit first.
- R4: With `fmt_8bit` = 0 the frame carries data bits 0..6 and ignores bit 7. With `fmt_8bit` = 1 it carries bits 0..7.
- R5: With `fmt_par` = 1 a parity bit follows the data (and the MP bit, if present). It equals the XOR of the sent data bits when `par_odd` = 0, and the inverse of that XOR when `par_odd` = 1. The MP bit is not included in the parity.
- R6: The frame ends with one high stop bit when `fmt_2stop` = 0 and two when `fmt_2stop` = 1. The line then stays high unless another transfer occurs.
- R7: With `mp_mode` = 1 the value of `wr_mpb` captured at the write is sent directly after the last data bit and before any parity bit. With `mp_mode` = 0 no such bit is sent.
- R8: A clock edge with `tx_en` = 0 ends any frame in progress, and `txd` is high from the next cycle. `tdre` and the held character do not change unless written. A pending character is sent in full once `tx_en` is 1 again.
- R9: When data is pending at the tick that ends the last stop bit, the next start bit begins at that same tick, with no idle bit between frames.
- R10: A write while a character is still pending replaces that character. Only the latest write is sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to transmit |
| wr_mpb | input | 1 | Multiprocessor marker bit for this character |
| tx_en | input | 1 | Transmitter enable; low aborts the frame |
| fmt_8bit | input | 1 | 1: eight data bits, 0: seven |
| fmt_par | input | 1 | 1: append parity bit |
| fmt_2stop | input | 1 | 1: two stop bits, 0: one |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| mp_mode | input | 1 | 1: insert multiprocessor marker bit |
| bit_tick | input | 1 | One-cycle pulse per bit interval |
| txd | output | 1 | Serial output, idles high |
| tdre | output | 1 | Holding register empty flag |

## Verification
Each kind of internal fault shows up at the ports within a bounded time:
- **Bit counter off by one.** The frame is one bit too long or too short, so the line level is wrong at the tick that should start the next frame or the idle state.
- **Bad holding-register flag.** `tdre` is wrong in the cycle after the write or transfer edge. A start bit also appears or goes missing on the next tick.
- **Wrong parity sense or misplaced MP bit.** Any character with an odd number of ones flips the affected bit on the wire within one bit interval.
- **Broken abort path.** The line stays low after the enable drops, or `tdre` changes, on the very next cycle.

// File: rtl/mptx_pkg.sv
package mptx_pkg;

    typedef struct packed {
        logic wide;      // 8 data bits when set
        logic par_en;    // parity bit appended
        logic two_stop;  // second stop bit
        logic odd;       // odd parity sense
        logic mp_on;     // multiprocessor marker inserted
    } mptx_fmt_t;

endpackage

// File: rtl/mptx_hold.sv
module mptx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_mpb,
    input  logic              take,
    output logic [DATA_W-1:0] data_o,
    output logic              mpb_o,
    output logic              full_o
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              mpb;
        logic              full;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (take) begin
            hold_d.full = 1'b0;
        end
        if (wr_en) begin
            hold_d.data = wr_data;
            hold_d.mpb  = wr_mpb;
            hold_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign data_o = hold_q.data;
    assign mpb_o  = hold_q.mpb;
    assign full_o = hold_q.full;

    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> full_o); // R2
    AST_TAKE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !wr_en) |=> !full_o); // R2

endmodule

// File: rtl/mptx_frame.sv
module mptx_frame
    import mptx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int FRAME_W = DATA_W + 5,
    parameter int CNT_W   = $clog2(FRAME_W)
) (
    input  logic [DATA_W-1:0]  data,
    input  logic               mpb,
    input  mptx_fmt_t          fmt,
    output logic [FRAME_W-1:0] frame_o,
    output logic [CNT_W-1:0]   last_idx_o
);

    logic [DATA_W-1:0] mask;
    logic              par_bit;
    logic [CNT_W-1:0]  pos;

    always_comb begin
        mask = fmt.wide ? {DATA_W{1'b1}} : {1'b0, {(DATA_W-1){1'b1}}};
        par_bit = (^(data & mask)) ^ fmt.odd;
        frame_o    = '1;
        frame_o[0] = 1'b0;
        pos = CNT_W'(1);
        for (int i = 0; i < DATA_W; i++) begin
            if (mask[i]) begin
                frame_o[pos] = data[i];
                pos = pos + CNT_W'(1);
            end
        end
        if (fmt.mp_on) begin
            frame_o[pos] = mpb;
            pos = pos + CNT_W'(1);
        end
        if (fmt.par_en) begin
            frame_o[pos] = par_bit;
            pos = pos + CNT_W'(1);
        end
        pos = pos + (fmt.two_stop ? CNT_W'(2) : CNT_W'(1));
        last_idx_o = pos - CNT_W'(1);
    end

endmodule

// File: rtl/mptx_shift.sv
module mptx_shift #(
    parameter int FRAME_W = 13,
    parameter int CNT_W   = $clog2(FRAME_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_en,
    input  logic               bit_tick,
    input  logic               pending,
    input  logic [FRAME_W-1:0] frame,
    input  logic [CNT_W-1:0]   last_idx,
    output logic               load_o,
    output logic               txd_o
);

    typedef struct packed {
        logic               busy;
        logic [FRAME_W-1:0] sr;
        logic [CNT_W-1:0]   cnt;
    } shift_t;

    shift_t sh_d, sh_q;
    logic   on_last;

    always_comb begin
        sh_d    = sh_q;
        on_last = sh_q.busy && (sh_q.cnt == '0);
        load_o  = tx_en && bit_tick && pending && (!sh_q.busy || on_last);
        if (!tx_en) begin
            sh_d.busy = 1'b0;
        end else if (bit_tick) begin
            if (load_o) begin
                sh_d.busy = 1'b1;
                sh_d.sr   = frame;
                sh_d.cnt  = last_idx;
            end else if (on_last) begin
                sh_d.busy = 1'b0;
            end else if (sh_q.busy) begin
                sh_d.sr  = {1'b1, sh_q.sr[FRAME_W-1:1]};
                sh_d.cnt = sh_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '{busy: 1'b0, sr: '1, cnt: '0};
        end else begin
            sh_q <= sh_d;
        end
    end

    assign txd_o = sh_q.busy ? sh_q.sr[0] : 1'b1;

    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !txd_o); // R3
    AST_ABORT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> txd_o); // R8
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !bit_tick && $past(tx_en)) |=> $stable(txd_o)); // R3

endmodule

// File: rtl/mptx_top.sv
module mptx_top
    import mptx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_mpb,
    input  logic              tx_en,
    input  logic              fmt_8bit,
    input  logic              fmt_par,
    input  logic              fmt_2stop,
    input  logic              par_odd,
    input  logic              mp_mode,
    input  logic              bit_tick,
    output logic              txd,
    output logic              tdre
);

    localparam int FRAME_W = DATA_W + 5;
    localparam int CNT_W   = $clog2(FRAME_W);

    mptx_fmt_t          fmt;
    logic [DATA_W-1:0]  held_data;
    logic               held_mpb;
    logic               held_full;
    logic               load;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   last_idx;

    assign fmt = '{wide: fmt_8bit, par_en: fmt_par, two_stop: fmt_2stop,
                   odd: par_odd, mp_on: mp_mode};

    mptx_hold #(.DATA_W(DATA_W)) i_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .wr_mpb  (wr_mpb),
        .take    (load),
        .data_o  (held_data),
        .mpb_o   (held_mpb),
        .full_o  (held_full)
    );

    mptx_frame #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) i_frame (
        .data       (held_data),
        .mpb        (held_mpb),
        .fmt        (fmt),
        .frame_o    (frame),
        .last_idx_o (last_idx)
    );

    mptx_shift #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) i_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_en    (tx_en),
        .bit_tick (bit_tick),
        .pending  (held_full),
        .frame    (frame),
        .last_idx (last_idx),
        .load_o   (load),
        .txd_o    (txd)
    );

    assign tdre = !held_full;

    AST_WRITE_CLEARS_TDRE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !tdre); // R2
    AST_TDRE_SET_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !wr_en) |=> tdre); // R2
    AST_ABORT_KEEPS_TDRE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !wr_en) |=> $stable(tdre)); // R8
    AST_NO_LOAD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> !load); // R8

endmodule

// File: tb/test_mptx_top.sv
module test_mptx_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_mpb = 1'b0;
    logic       tx_en = 1'b0;
    logic       fmt_8bit = 1'b1;
    logic       fmt_par = 1'b0;
    logic       fmt_2stop = 1'b0;
    logic       par_odd = 1'b0;
    logic       mp_mode = 1'b0;
    logic       bit_tick = 1'b0;
    logic       txd;
    logic       tdre;

    int    vectors = 0;
    int    miscompares = 0;
    bit    finished = 1'b0;
    string phase = "R1";

    always #5 clk = ~clk;

    mptx_top i_mptx_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .wr_mpb    (wr_mpb),
        .tx_en     (tx_en),
        .fmt_8bit  (fmt_8bit),
        .fmt_par   (fmt_par),
        .fmt_2stop (fmt_2stop),
        .par_odd   (par_odd),
        .mp_mode   (mp_mode),
        .bit_tick  (bit_tick),
        .txd       (txd),
        .tdre      (tdre)
    );

    // tick every fourth clock, changed on the falling edge
    int tick_div = 0;
    always @(negedge clk) begin
        tick_div = (tick_div + 1) % 4;
        bit_tick <= (tick_div == 0);
    end

    // behavioural reference: queue of bits still to appear on the line
    bit       line_q[$];
    bit       m_pend = 1'b0;
    bit [7:0] m_data = '0;
    bit       m_mpb = 1'b0;

    task automatic build_frame();
        int n;
        bit p;
        n = fmt_8bit ? 8 : 7;
        p = par_odd;
        line_q.push_back(1'b0);
        for (int i = 0; i < n; i++) begin
            line_q.push_back(m_data[i]);
            p = p ^ m_data[i];
        end
        if (mp_mode) line_q.push_back(m_mpb);
        if (fmt_par) line_q.push_back(p);
        line_q.push_back(1'b1);
        if (fmt_2stop) line_q.push_back(1'b1);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            line_q.delete();
            m_pend = 1'b0;
        end else begin
            if (!tx_en) begin
                line_q.delete();
            end else if (bit_tick) begin
                if (line_q.size() > 0) void'(line_q.pop_front());
                if (line_q.size() == 0 && m_pend) begin
                    build_frame();
                    m_pend = 1'b0;
                end
            end
            if (wr_en) begin
                m_pend = 1'b1;
                m_data = wr_data;
                m_mpb  = wr_mpb;
            end
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        bit exp_txd;
        bit exp_tdre;
        if (!finished) begin
            exp_txd  = (line_q.size() > 0) ? line_q[0] : 1'b1;
            exp_tdre = !m_pend;
            vectors++;
            if (txd !== exp_txd) begin
                miscompares++;
                $display("FAIL %s txd actual=%b expected=%b at %0t", phase, txd, exp_txd, $time);
            end
            if (tdre !== exp_tdre) begin
                miscompares++;
                $display("FAIL %s tdre actual=%b expected=%b at %0t", phase, tdre, exp_tdre, $time);
            end
        end
    end

    task automatic wait_clk(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_char(logic [7:0] d, logic mpb);
        @(negedge clk);
        wr_data = d;
        wr_mpb  = mpb;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_fmt(logic w8, logic par, logic s2, logic odd, logic mp);
        fmt_8bit  = w8;
        fmt_par   = par;
        fmt_2stop = s2;
        par_odd   = odd;
        mp_mode   = mp;
    endtask

    initial begin
        phase = "R1";
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(4);
        tx_en = 1'b1;

        phase = "R3";
        set_fmt(1, 0, 0, 0, 0);
        write_char(8'hA5, 0);
        wait_clk(60);
        write_char(8'h3C, 0);
        wait_clk(60);

        phase = "R4";
        set_fmt(0, 0, 0, 0, 0);
        write_char(8'hC1, 0);
        wait_clk(60);

        phase = "R5";
        set_fmt(1, 1, 0, 0, 0);
        write_char(8'h07, 0);
        wait_clk(60);
        set_fmt(1, 1, 0, 1, 0);
        write_char(8'h07, 0);
        wait_clk(60);
        set_fmt(0, 1, 0, 1, 0);
        write_char(8'hFE, 0);
        wait_clk(60);

        phase = "R6";
        set_fmt(1, 0, 1, 0, 0);
        write_char(8'h00, 0);
        wait_clk(60);

        phase = "R7";
        set_fmt(1, 1, 0, 0, 1);
        write_char(8'h81, 1);
        wait_clk(60);
        set_fmt(0, 1, 1, 1, 1);
        write_char(8'h55, 0);
        wait_clk(60);

        phase = "R9";
        set_fmt(1, 1, 1, 0, 0);
        write_char(8'h12, 0);
        wait_clk(6);
        write_char(8'hED, 0);
        wait_clk(120);

        phase = "R10";
        tx_en = 1'b0;
        write_char(8'h11, 0);
        write_char(8'h99, 1);
        wait_clk(3);
        tx_en = 1'b1;
        wait_clk(70);

        phase = "R8";
        set_fmt(1, 0, 0, 0, 0);
        write_char(8'hF0, 0);
        wait_clk(14);
        tx_en = 1'b0;
        wait_clk(3);
        write_char(8'h0F, 0);
        wait_clk(5);
        tx_en = 1'b1;
        wait_clk(70);

        phase = "R2";
        write_char(8'h5A, 0);
        write_char(8'h6B, 0);
        wait_clk(120);

        phase = "R1";
        rst_n = 1'b0;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(4);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            finished = 1'b1;
            miscompares++;
            $display("FAIL watchdog expired in phase %s", phase);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule